// File: doc/BRIEF.md
# Self-Testing 2x2 Multiplier with Signature Compaction

This block wraps a small combinational circuit under test, a 2-bit by 2-bit unsigned multiplier, with the machinery it needs to test itself. A 4-bit linear feedback shift register (LFSR) produces pseudo-random stimulus. Its feedback comes from a primitive polynomial, so one run walks through every nonzero 4-bit value exactly once. Each value is split into the two multiplier operands. Each 4-bit product is folded into a multiple-input signature register (MISR), so no response is stored.

A one-cycle start pulse launches a run of fifteen clocks. At the end the accumulated signature is compared against a golden value held as a parameter, and the block reports pass or fail. A fault-select input swaps in a deliberately defective multiplier, which shows that the compacted signature exposes wrong products.

Top module: `lbist_mult`

## Requirements
- R1: The pattern register starts from the seed 4'b0001 at every run start. It shifts toward the MSB and feeds the XOR of bits 3 and 2 into bit 0, following x^4 + x^3 + 1. A run therefore applies 15 distinct nonzero patterns, and the register holds the seed again when the run ends.
- R2: Operand A is pattern bits [3:2] and operand B is pattern bits [1:0]. The fault-free product is the 4-bit unsigned A*B, formed as the sum of partial products that each shift one place further left.
- R3: The signature register is 4'b0000 after reset and after each run start. On each run cycle it becomes {s[2:0], s[3]^s[2]} XOR product. The signature port shows this register.
- R4: When a run ends, the signature is compared with the GOLDEN parameter, whose default 4'b0100 is the fault-free result. A match gives pass=1, fail=0. A mismatch gives fail=1, pass=0. Both outputs are 0 after reset and during a run.
- R5: A start pulse while idle raises busy on the next clock. busy stays high for exactly 15 cycles.
- R6: done is high for one cycle, in the first cycle after busy falls. pass and fail keep their values until the next accepted start.
- R7: start is ignored while busy is high. The run length and the final signature do not change.
- R8: With fault_sel high, the defective multiplier forces product bit 0 to 0 and ORs operand B bit 1 into product bit 1. For example, 0*3 gives 2 and 3*1 gives 2. A full run then ends with signature 4'b0111 and fail=1.
- R9: During reset, busy, done, pass and fail are 0 and the signature is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches a run when the block is idle |
| fault_sel | input | 1 | Selects the defective multiplier model |
| busy | output | 1 | High while patterns are being applied |
| done | output | 1 | One-cycle pulse when a run ends |
| pass | output | 1 | Final signature matched the golden value |
| fail | output | 1 | Final signature differed from the golden value |
| signature | output | 4 | Current MISR contents |

## Verification
The bench builds the block with its default parameters: 2-bit operands, seed 4'b0001, feedback mask 4'b1100 and golden value 4'b0100. With these values a full 15-pattern period fits in a few dozen cycles, so the bench can follow every pattern and signature step of both the fault-free and the defective run. The small width also lets the bench confirm that all 15 nonzero patterns are distinct. It also checks that the two final signatures, 4'b0100 and 4'b0111, differ, and that a start pulse in mid-run leaves both the run length and the signature unchanged.

// File: rtl/lbist_mult.sv
`timescale 1ns/1ps
module lbist_mult #(
  parameter int OPW = 2,
  parameter logic [2*OPW-1:0] SEED   = 'b0001,
  parameter logic [2*OPW-1:0] TAPS   = 'b1100,
  parameter logic [2*OPW-1:0] GOLDEN = 'b0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            fault_sel,
  output logic            busy,
  output logic            done,
  output logic            pass,
  output logic            fail,
  output logic [2*OPW-1:0] signature
);
  localparam int PW  = 2 * OPW;
  localparam int RUN = (1 << PW) - 1;
  localparam int CW  = $clog2(RUN + 1);

  logic [PW-1:0] lfsr, prod_ok, prod_bad, prod, sig_nxt;
  logic [CW-1:0] cnt;
  logic [OPW-1:0] op_a, op_b;

  assign op_a = lfsr[PW-1:OPW];
  assign op_b = lfsr[OPW-1:0];

  always_comb begin
    prod_ok = '0;
    for (int i = 0; i < OPW; i++)
      if (op_b[i]) prod_ok = prod_ok + (PW'(op_a) << i);
  end

  assign prod_bad = {prod_ok[PW-1:2], prod_ok[1] | op_b[OPW-1], 1'b0};
  assign prod     = fault_sel ? prod_bad : prod_ok;
  assign sig_nxt  = {signature[PW-2:0], ^(signature & TAPS)} ^ prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr <= SEED; signature <= '0; cnt <= '0;
      busy <= 1'b0; done <= 1'b0; pass <= 1'b0; fail <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        lfsr      <= {lfsr[PW-2:0], ^(lfsr & TAPS)};
        signature <= sig_nxt;
        cnt       <= cnt + 1'b1;
        if (cnt == CW'(RUN - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          pass <= (sig_nxt == GOLDEN);
          fail <= (sig_nxt != GOLDEN);
        end
      end else if (start) begin
        lfsr <= SEED; signature <= '0; cnt <= '0;
        busy <= 1'b1; pass <= 1'b0; fail <= 1'b0;
      end
    end
  end

  // R1: patterns stay nonzero and wrap back to the seed after a full period
  p_nonzero_r1: assert property (@(posedge clk) disable iff (rst) busy |-> lfsr != '0);
  p_wrap_r1:    assert property (@(posedge clk) disable iff (rst) done |-> lfsr == SEED);
  // R4: verdict outputs are exclusive and only set at run end
  p_excl_r4:    assert property (@(posedge clk) disable iff (rst) !(pass && fail));
  p_clear_r4:   assert property (@(posedge clk) disable iff (rst) busy |-> !pass && !fail);
  // R5: last counted step ends the run
  p_len_r5:     assert property (@(posedge clk) disable iff (rst)
                  busy && cnt == CW'(RUN - 1) |=> done && !busy);
  // R6: done is a single pulse; verdict holds while idle
  p_pulse_r6:   assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_hold_r6:    assert property (@(posedge clk) disable iff (rst)
                  !busy && !start |=> $stable(pass) && $stable(fail));
  // R7: start during a run does not restart the count
  p_ignore_r7:  assert property (@(posedge clk) disable iff (rst)
                  busy && start && cnt != CW'(RUN - 1) |=> busy && cnt == $past(cnt) + 1'b1);
endmodule

// File: tb/lbist_mult_tb_top.sv
`timescale 1ns/1ps
module lbist_mult_tb_top;
  logic clk = 0, rst = 1, start = 0, fault_sel = 0;
  logic busy, done, pass, fail;
  logic [3:0] signature;
  int checks = 0, fails = 0;
  localparam int GOLD = 4;

  always #4 clk = ~clk;

  lbist_mult dut_i (.clk(clk), .rst(rst), .start(start), .fault_sel(fault_sel),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .signature(signature));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_lfsr, m_sig, m_cnt;
  bit m_busy, m_done, m_pass, m_fail, rec = 1, started = 0;
  int pats[$];

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_lfsr = 1; m_sig = 0; m_cnt = 0;
      m_busy = 0; m_done = 0; m_pass = 0; m_fail = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        int a, b, p;
        a = m_lfsr / 4; b = m_lfsr % 4; p = a * b;
        if (fault_sel) p = (p & 12) | ((((p >> 1) | (b >> 1)) & 1) << 1);
        if (rec) pats.push_back(m_lfsr);
        m_sig  = (((m_sig * 2) % 16) | (((m_sig >> 3) ^ (m_sig >> 2)) & 1)) ^ p;
        m_lfsr = (((m_lfsr * 2) % 16) | (((m_lfsr >> 3) ^ (m_lfsr >> 2)) & 1));
        m_cnt++;
        if (m_cnt == 15) begin
          m_busy = 0; m_done = 1; m_pass = (m_sig == GOLD); m_fail = !m_pass;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0; m_lfsr = 1; m_sig = 0; m_pass = 0; m_fail = 0;
      end
    end
  end

  always @(negedge clk) if (started) begin
    chk("R5", "busy vs model", busy, m_busy);
    chk("R6", "done vs model", done, m_done);
    chk("R4", "pass vs model", pass, m_pass);
    chk("R4", "fail vs model", fail, m_fail);
    chk("R3", "signature vs model", signature, m_sig);
  end

  task automatic run(input bit f, input bit poke, input int exp_sig, input string req);
    int nb = 0;
    fault_sel = f; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 40 && !done; i++) begin
      if (busy) nb++;
      start = (poke && i == 6);
      @(negedge clk);
    end
    start = 0;
    chk("R5", "busy cycle count", nb, 15);
    chk(req, "final signature", signature, exp_sig);
    chk(req, "pass at end", pass, exp_sig == GOLD);
    chk(req, "fail at end", fail, exp_sig != GOLD);
    @(negedge clk);
    chk("R6", "done one cycle only", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset busy", busy, 0);
    chk("R9", "reset done", done, 0);
    chk("R9", "reset pass", pass, 0);
    chk("R9", "reset fail", fail, 0);
    chk("R9", "reset signature", signature, 0);
    rst = 0;
    repeat (2) @(negedge clk);

    run(0, 0, 4'b0100, "R4");
    rec = 0;
    chk("R1", "pattern count", pats.size(), 15);
    foreach (pats[i]) begin
      chk("R1", "pattern nonzero", pats[i] != 0, 1);
      for (int j = i + 1; j < pats.size(); j++)
        chk("R1", "pattern distinct", pats[i] != pats[j], 1);
    end
    chk("R2", "pattern 0x9 gives product 2", (9 / 4) * (9 % 4), 2);

    repeat (5) @(negedge clk);
    chk("R6", "pass held while idle", pass, 1);
    chk("R6", "fail held while idle", fail, 0);

    run(1, 0, 4'b0111, "R8");
    repeat (3) @(negedge clk);
    chk("R6", "fail held while idle", fail, 1);

    run(0, 1, 4'b0100, "R7");
    run(1, 1, 4'b0111, "R7");
    run(0, 0, 4'b0100, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule